// File: doc/BRIEF.md
# Machine-Mode Trap Entry Controller

This block decides, once per clock, whether a single-hart core with machine, supervisor and user privilege levels takes a trap, and of what kind. It takes synchronous exception requests, an environment-call request and three interrupt lines (external, timer, software). Interrupts are qualified against the enable and delegation registers. Among the active sources it picks the winner by fixed priority. It then either performs a machine-level trap entry or reports that the trap goes to the supervisor level. A machine entry writes the cause and trap-value registers, stacks the status fields, raises the privilege to machine, and produces a redirect target in direct or vectored form.

The block also holds the exception-delegation, interrupt-delegation, interrupt-enable, status and trap-vector registers, written through a small select/data port. It executes the return-from-machine-trap operation. Flushing the pipeline, page-fault causes and the supervisor entry sequence are left to neighbouring logic. A delegated trap is reported through `s_trap_o`/`s_cause_o`, and the privilege moves to supervisor.

Top module: `mtrap_ctrl`

## Requirements
- R1: While and after reset, with no stimulus, privilege reads machine (2'b11) and every register output, `redirect_o` and `s_trap_o` read zero.
- R2: `exc_vec_i` bit n-1 requests exception code n (1 instruction access fault, 2 illegal instruction, 3 breakpoint, 4 load misaligned, 5 load access fault, 6 store misaligned, 7 store access fault). When several requests arrive together, the winner follows the order 3, 1, 2, environment call, 4, 6, 5, 7.
- R3: An environment call (`ecall_i`) takes code 8 from user, 9 from supervisor and 11 from machine level.
- R4: `mtval_o` receives `fault_addr_i` for codes 1 and 3 to 7. It receives zero for code 2, for environment calls and for interrupts.
- R5: A machine trap sets status bits 12:11 to the privilege it came from, copies bit 3 into bit 7, clears bit 3 and sets the privilege to machine. These results and a one-cycle `redirect_o` pulse appear on the clock edge that samples the request.
- R6: Only bits of `EDELEG_MASK` (default 0xB309) are writable in the exception-delegation register, only bits of `IDELEG_MASK` (default 0x222) in the interrupt-delegation register, and only bits of `IEN_MASK` (default 0xAAA) in the interrupt-enable register.
- R7: A trap raised at machine level always enters machine level, whatever the delegation bits hold. An exception from supervisor or user level whose delegation bit is set instead pulses `s_trap_o` with the cause on `s_cause_o` and sets privilege to supervisor. The machine cause, value and status registers are left unchanged.
- R8: `mip_o` combinationally shows the external input on bit 11, the timer input on bit 7 and the software input on bit 3. Bit 9 shows external ANDed with interrupt-delegation bit 9, and bit 5 shows timer ANDed with interrupt-delegation bit 5.
- R9: A machine interrupt (bits 11, 3, 7, in that priority) is taken when it is pending and enabled and either status bit 3 is set or the privilege is below machine. Interrupts win over exceptions in the same cycle. The cause has its most significant bit set and the code in the low bits.
- R10: A supervisor interrupt (bits 9 then 5) that is pending and enabled, with no machine interrupt taken, pulses `s_trap_o` and moves to supervisor only when privilege is below machine. At machine level it has no effect.
- R11: A trap-vector write stores bits XLEN-1:2 as base and bit 0 as mode (1 = vectored), with bit 1 reading zero. Exceptions and direct-mode interrupts redirect to the base. Vectored interrupts redirect to base plus four times the code.
- R12: A return at machine level copies bit 7 to bit 3, sets bit 7, moves to the privilege held in bits 12:11 and sets those bits to user. A return below machine level has no effect.
- R13: A register write in the same cycle as a taken trap or return is dropped. A status write with bits 12:11 equal to 2'b10 leaves those bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_vec_i | input | 7 | Exception requests, bit n-1 for code n |
| ecall_i | input | 1 | Environment-call request |
| fault_addr_i | input | XLEN | Faulting address for the trap value |
| mret_i | input | 1 | Return from machine trap |
| ext_irq_i | input | 1 | External interrupt line |
| timer_irq_i | input | 1 | Timer interrupt line |
| sw_irq_i | input | 1 | Software interrupt line |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 3 | Write select: 0 status, 1 exception delegation, 2 interrupt delegation, 3 interrupt enable, 4 trap vector |
| csr_wdata_i | input | XLEN | Write data |
| priv_o | output | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| mstatus_o | output | XLEN | Status: bit 3 enable, bit 7 previous enable, bits 12:11 previous privilege |
| medeleg_o | output | XLEN | Exception-delegation register |
| mideleg_o | output | XLEN | Interrupt-delegation register |
| mie_o | output | XLEN | Interrupt-enable register |
| mip_o | output | XLEN | Interrupt-pending view |
| mtvec_o | output | XLEN | Trap-vector register |
| mcause_o | output | XLEN | Machine trap cause |
| mtval_o | output | XLEN | Machine trap value |
| redirect_o | output | 1 | One-cycle pulse after a machine trap entry |
| target_o | output | XLEN | Redirect address |
| s_trap_o | output | 1 | One-cycle pulse after a delegated trap |
| s_cause_o | output | XLEN | Cause of the delegated trap |

## Verification
All trap, return and register-write results are registered, so they are due on the first rising edge after the stimulus is applied. The bench drives stimulus one nanosecond after an edge, waits for the next edge and samples one nanosecond later, then removes the stimulus. The pending view is the one combinational result. It is checked while the interrupt lines are held, before the edge that would act on them. A stimulus that must have no effect is followed by a check of the register and privilege outputs it could have changed.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_EDELEG = 3'd1,
    SEL_IDELEG = 3'd2,
    SEL_IEN    = 3'd3,
    SEL_TVEC   = 3'd4
  } csr_sel_e;

  localparam int CODE_W   = 4;
  localparam int IRQ_W    = 12;
  localparam int EXC_N    = 7;
  localparam int ST_IE    = 3;
  localparam int ST_PIE   = 7;
  localparam int ST_PP_LO = 11;

  localparam logic [CODE_W-1:0] C_ILLEGAL  = 4'd2;
  localparam logic [CODE_W-1:0] C_ECALL_U  = 4'd8;
  localparam logic [CODE_W-1:0] C_ECALL_S  = 4'd9;
  localparam logic [CODE_W-1:0] C_ECALL_M  = 4'd11;

endpackage

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb
  import mtrap_pkg::*;
(
  input  logic              ext_i,
  input  logic              timer_i,
  input  logic              sw_i,
  input  logic              sext_deleg_i,
  input  logic              stim_deleg_i,
  input  logic [IRQ_W-1:0]  ien_i,
  input  priv_e             priv_i,
  input  logic              gie_i,
  output logic [IRQ_W-1:0]  pend_o,
  output logic              m_take_o,
  output logic [CODE_W-1:0] m_code_o,
  output logic              s_take_o,
  output logic [CODE_W-1:0] s_code_o
);
  localparam int M_N = 3;
  localparam int S_N = 2;
  localparam int M_ORDER [M_N] = '{11, 3, 7};
  localparam int S_ORDER [S_N] = '{9, 5};
  localparam logic [IRQ_W-1:0] M_MASK = 12'h888;
  localparam logic [IRQ_W-1:0] S_MASK = 12'h220;

  logic [IRQ_W-1:0] act;

  always_comb begin
    pend_o     = '0;
    pend_o[11] = ext_i;
    pend_o[9]  = ext_i & sext_deleg_i;
    pend_o[7]  = timer_i;
    pend_o[5]  = timer_i & stim_deleg_i;
    pend_o[3]  = sw_i;
  end

  assign act = pend_o & ien_i;

  // highest priority is the first list entry: scan from the back
  always_comb begin
    m_code_o = '0;
    for (int k = M_N - 1; k >= 0; k--) begin
      if (act[M_ORDER[k]]) m_code_o = CODE_W'(M_ORDER[k]);
    end
    s_code_o = '0;
    for (int k = S_N - 1; k >= 0; k--) begin
      if (act[S_ORDER[k]]) s_code_o = CODE_W'(S_ORDER[k]);
    end
  end

  assign m_take_o = (|(act & M_MASK)) && (priv_i != PRIV_M || gie_i);
  assign s_take_o = (|(act & S_MASK)) && (priv_i != PRIV_M);

endmodule

// File: rtl/mtrap_exc_arb.sv
module mtrap_exc_arb
  import mtrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [EXC_N-1:0]  exc_vec_i,
  input  logic              ecall_i,
  input  priv_e             priv_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic [XLEN-1:0]   tval_o
);
  localparam int REQ_N = EXC_N + 1;
  // slot 0 stands for the environment call
  localparam int ORDER [REQ_N] = '{3, 1, 2, 0, 4, 6, 5, 7};

  logic [REQ_N-1:0]  req;
  logic [CODE_W-1:0] ecall_code;
  logic              sel_ecall;

  assign req = {exc_vec_i, ecall_i};

  always_comb begin
    unique case (priv_i)
      PRIV_M:  ecall_code = C_ECALL_M;
      PRIV_S:  ecall_code = C_ECALL_S;
      default: ecall_code = C_ECALL_U;
    endcase
  end

  always_comb begin
    valid_o   = 1'b0;
    code_o    = '0;
    sel_ecall = 1'b0;
    for (int k = REQ_N - 1; k >= 0; k--) begin
      if (req[ORDER[k]]) begin
        valid_o   = 1'b1;
        sel_ecall = (ORDER[k] == 0);
        code_o    = (ORDER[k] == 0) ? ecall_code : CODE_W'(ORDER[k]);
      end
    end
  end

  assign tval_o = (sel_ecall || code_o == C_ILLEGAL) ? '0 : fault_addr_i;

endmodule

// File: rtl/mtrap_vec_tgt.sv
module mtrap_vec_tgt
  import mtrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic              vectored_i,
  input  logic              is_irq_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   target_o
);
  localparam int PAD_W = XLEN - CODE_W - 2;

  logic [XLEN-1:0] offset;

  assign offset   = {{PAD_W{1'b0}}, code_i, 2'b00};
  assign target_o = (vectored_i && is_irq_i) ? base_i + offset : base_i;

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
  import mtrap_pkg::*;
#(
  parameter int          XLEN        = 64,
  parameter logic [63:0] EDELEG_MASK = 64'hB309,
  parameter logic [63:0] IDELEG_MASK = 64'h222,
  parameter logic [11:0] IEN_MASK    = 12'hAAA
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [6:0]      exc_vec_i,
  input  logic            ecall_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic            mret_i,
  input  logic            ext_irq_i,
  input  logic            timer_irq_i,
  input  logic            sw_irq_i,
  input  logic            csr_we_i,
  input  logic [2:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] medeleg_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mtval_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            s_trap_o,
  output logic [XLEN-1:0] s_cause_o
);
  localparam int CZ_W = XLEN - 1 - CODE_W;
  localparam logic [XLEN-1:0] ED_M = XLEN'(EDELEG_MASK);
  localparam logic [XLEN-1:0] ID_M = XLEN'(IDELEG_MASK);

  // architectural state
  priv_e             priv_q;
  logic              st_ie_q, st_pie_q;
  priv_e             st_pp_q;
  logic [XLEN-1:0]   edeleg_q, ideleg_q, tvec_q, cause_q, tval_q;
  logic [IRQ_W-1:0]  ien_q;
  logic              redir_q, s_trap_q;
  logic [XLEN-1:0]   target_q, s_cause_q;

  // arbiter results
  logic [IRQ_W-1:0]  pend;
  logic              irq_m, irq_s;
  logic [CODE_W-1:0] irq_m_code, irq_s_code;
  logic              exc_v;
  logic [CODE_W-1:0] exc_code;
  logic [XLEN-1:0]   exc_tval;

  // decision
  logic              take_m, take_s, is_irq, do_ret, wr_ok;
  logic [CODE_W-1:0] code_w;
  logic [XLEN-1:0]   tval_w, cause_w, tgt_w, base_w;

  mtrap_irq_arb u_irq (
    .ext_i        (ext_irq_i),
    .timer_i      (timer_irq_i),
    .sw_i         (sw_irq_i),
    .sext_deleg_i (ideleg_q[9]),
    .stim_deleg_i (ideleg_q[5]),
    .ien_i        (ien_q),
    .priv_i       (priv_q),
    .gie_i        (st_ie_q),
    .pend_o       (pend),
    .m_take_o     (irq_m),
    .m_code_o     (irq_m_code),
    .s_take_o     (irq_s),
    .s_code_o     (irq_s_code)
  );

  mtrap_exc_arb #(.XLEN(XLEN)) u_exc (
    .exc_vec_i    (exc_vec_i),
    .ecall_i      (ecall_i),
    .priv_i       (priv_q),
    .fault_addr_i (fault_addr_i),
    .valid_o      (exc_v),
    .code_o       (exc_code),
    .tval_o       (exc_tval)
  );

  assign base_w = {tvec_q[XLEN-1:2], 2'b00};

  mtrap_vec_tgt #(.XLEN(XLEN)) u_tgt (
    .base_i     (base_w),
    .vectored_i (tvec_q[0]),
    .is_irq_i   (is_irq),
    .code_i     (code_w),
    .target_o   (tgt_w)
  );

  always_comb begin
    take_m = 1'b0;
    take_s = 1'b0;
    is_irq = 1'b0;
    code_w = '0;
    tval_w = '0;
    if (irq_m) begin
      take_m = 1'b1;
      is_irq = 1'b1;
      code_w = irq_m_code;
    end else if (irq_s) begin
      take_s = 1'b1;
      is_irq = 1'b1;
      code_w = irq_s_code;
    end else if (exc_v) begin
      code_w = exc_code;
      tval_w = exc_tval;
      // traps raised at machine level never leave it
      if (priv_q != PRIV_M && edeleg_q[exc_code]) take_s = 1'b1;
      else                                         take_m = 1'b1;
    end
  end

  assign cause_w = {is_irq, {CZ_W{1'b0}}, code_w};
  assign do_ret  = mret_i && priv_q == PRIV_M && !take_m && !take_s;
  assign wr_ok   = csr_we_i && !take_m && !take_s && !do_ret;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q    <= PRIV_M;
      st_ie_q   <= 1'b0;
      st_pie_q  <= 1'b0;
      st_pp_q   <= PRIV_U;
      edeleg_q  <= '0;
      ideleg_q  <= '0;
      ien_q     <= '0;
      tvec_q    <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
      redir_q   <= 1'b0;
      target_q  <= '0;
      s_trap_q  <= 1'b0;
      s_cause_q <= '0;
    end else begin
      redir_q  <= take_m;
      s_trap_q <= take_s;
      if (take_m) begin
        cause_q  <= cause_w;
        tval_q   <= tval_w;
        target_q <= tgt_w;
        st_pp_q  <= priv_q;
        st_pie_q <= st_ie_q;
        st_ie_q  <= 1'b0;
        priv_q   <= PRIV_M;
      end else if (take_s) begin
        s_cause_q <= cause_w;
        priv_q    <= PRIV_S;
      end else if (do_ret) begin
        st_ie_q  <= st_pie_q;
        st_pie_q <= 1'b1;
        priv_q   <= st_pp_q;
        st_pp_q  <= PRIV_U;
      end
      if (wr_ok) begin
        unique case (csr_sel_e'(csr_sel_i))
          SEL_STATUS: begin
            st_ie_q  <= csr_wdata_i[ST_IE];
            st_pie_q <= csr_wdata_i[ST_PIE];
            if (csr_wdata_i[ST_PP_LO+1:ST_PP_LO] != 2'b10)
              st_pp_q <= priv_e'(csr_wdata_i[ST_PP_LO+1:ST_PP_LO]);
          end
          SEL_EDELEG: edeleg_q <= csr_wdata_i & ED_M;
          SEL_IDELEG: ideleg_q <= csr_wdata_i & ID_M;
          SEL_IEN:    ien_q    <= csr_wdata_i[IRQ_W-1:0] & IEN_MASK;
          SEL_TVEC:   tvec_q   <= {csr_wdata_i[XLEN-1:2], 1'b0, csr_wdata_i[0]};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    mstatus_o                        = '0;
    mstatus_o[ST_IE]                 = st_ie_q;
    mstatus_o[ST_PIE]                = st_pie_q;
    mstatus_o[ST_PP_LO+1:ST_PP_LO]   = st_pp_q;
  end

  assign priv_o     = priv_q;
  assign medeleg_o  = edeleg_q;
  assign mideleg_o  = ideleg_q;
  assign mie_o      = XLEN'(ien_q);
  assign mip_o      = XLEN'(pend);
  assign mtvec_o    = tvec_q;
  assign mcause_o   = cause_q;
  assign mtval_o    = tval_q;
  assign redirect_o = redir_q;
  assign target_o   = target_q;
  assign s_trap_o   = s_trap_q;
  assign s_cause_o  = s_cause_q;

endmodule

// File: rtl/mtrap_ctrl_chk.sv
module mtrap_ctrl_chk #(
  parameter int          XLEN        = 64,
  parameter logic [63:0] EDELEG_MASK = 64'hB309,
  parameter logic [63:0] IDELEG_MASK = 64'h222
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [6:0]      exc_vec_i,
  input logic            ecall_i,
  input logic            mret_i,
  input logic            ext_irq_i,
  input logic            timer_irq_i,
  input logic            sw_irq_i,
  input logic            csr_we_i,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] mstatus_o,
  input logic [XLEN-1:0] medeleg_o,
  input logic [XLEN-1:0] mideleg_o,
  input logic [XLEN-1:0] mtvec_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] mtval_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic            s_trap_o
);
  localparam logic [XLEN-1:0] ALIGN = ~XLEN'(3);

  a_r7_single_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_o && s_trap_o));

  a_r7_m_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o == 2'b11 |=> !s_trap_o);

  a_r5_entry_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (priv_o == 2'b11 && !mstatus_o[3]));

  a_r6_edeleg_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (medeleg_o & ~XLEN'(EDELEG_MASK)) == '0);

  a_r6_ideleg_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mideleg_o & ~XLEN'(IDELEG_MASK)) == '0);

  a_r13_pp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstatus_o[12:11] != 2'b10);

  a_r11_exc_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !mcause_o[XLEN-1]) |-> target_o == (mtvec_o & ALIGN));

  a_r11_irq_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && mcause_o[XLEN-1] && mtvec_o[0])
      |-> target_o == (mtvec_o & ALIGN) + (mcause_o << 2));

  a_r4_zero_tval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && (mcause_o[XLEN-1] || mcause_o == XLEN'(2) || mcause_o == XLEN'(8) ||
                    mcause_o == XLEN'(9) || mcause_o == XLEN'(11))) |-> mtval_o == '0);

  a_r12_ret_below_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && priv_o != 2'b11 && !csr_we_i && exc_vec_i == '0 && !ecall_i &&
     !ext_irq_i && !timer_irq_i && !sw_irq_i) |=> ($stable(mstatus_o) && $stable(priv_o)));

endmodule

bind mtrap_ctrl mtrap_ctrl_chk #(
  .XLEN(XLEN), .EDELEG_MASK(EDELEG_MASK), .IDELEG_MASK(IDELEG_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exc_vec_i(exc_vec_i), .ecall_i(ecall_i),
  .mret_i(mret_i), .ext_irq_i(ext_irq_i), .timer_irq_i(timer_irq_i),
  .sw_irq_i(sw_irq_i), .csr_we_i(csr_we_i), .priv_o(priv_o),
  .mstatus_o(mstatus_o), .medeleg_o(medeleg_o), .mideleg_o(mideleg_o),
  .mtvec_o(mtvec_o), .mcause_o(mcause_o), .mtval_o(mtval_o),
  .redirect_o(redirect_o), .target_o(target_o), .s_trap_o(s_trap_o)
);

// File: tb/mtrap_ctrl_test.sv
`timescale 1ns/1ps
module mtrap_ctrl_test;
  localparam int XLEN = 64;
  localparam logic [63:0] IRQ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] VB  = 64'h8000_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] exc_vec = '0;
  logic ecall = 0, mret = 0, ext = 0, tmr = 0, sw = 0, we = 0;
  logic [2:0] sel = '0;
  logic [XLEN-1:0] wdata = '0, faddr = '0;
  logic [1:0] priv;
  logic [XLEN-1:0] mstatus, medeleg, mideleg, mie, mip, mtvec, mcause, mtval, target, s_cause;
  logic redirect, s_trap;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtrap_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .exc_vec_i(exc_vec), .ecall_i(ecall),
    .fault_addr_i(faddr), .mret_i(mret), .ext_irq_i(ext), .timer_irq_i(tmr),
    .sw_irq_i(sw), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
    .priv_o(priv), .mstatus_o(mstatus), .medeleg_o(medeleg), .mideleg_o(mideleg),
    .mie_o(mie), .mip_o(mip), .mtvec_o(mtvec), .mcause_o(mcause), .mtval_o(mtval),
    .redirect_o(redirect), .target_o(target), .s_trap_o(s_trap), .s_cause_o(s_cause)
  );

  // table: exception requests, ecall, tval is address, expected code
  localparam int NV = 14;
  localparam logic [6:0] T_VEC [NV] = '{7'h04, 7'h01, 7'h02, 7'h08, 7'h10, 7'h20, 7'h40,
                                        7'h00, 7'h7F, 7'h7A, 7'h78, 7'h70, 7'h50, 7'h03};
  localparam logic       T_ECL [NV] = '{0,0,0,0,0,0,0,1,1,0,1,0,0,0};
  localparam logic       T_ADR [NV] = '{1,1,0,1,1,1,1,0,1,0,0,1,1,1};
  localparam int         T_COD [NV] = '{3,1,2,4,5,6,7,11,3,2,11,6,5,1};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    exc_vec = '0; ecall = 0; mret = 0; ext = 0; tmr = 0; sw = 0; we = 0; faddr = '0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [63:0] d);
    we = 1; sel = s; wdata = d;
    step();
    we = 0;
  endtask

  task automatic ret();
    mret = 1;
    step();
    mret = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #9;
    chk("R1 priv", priv, 2'b11);
    chk("R1 mstatus", mstatus, 0);
    chk("R1 mcause", mcause, 0);
    chk("R1 deleg", medeleg | mideleg | mie | mtvec | mtval, 0);
    chk("R1 pulses", {redirect, s_trap}, 0);
    rst_n = 1;
    step();
    chk("R1 after release", {redirect, s_trap, priv}, 2'b11);

    wr(3'd4, 64'h8000_0103);
    chk("R11 tvec stored", mtvec, 64'h8000_0101);

    // exception table walk at machine level
    for (int i = 0; i < NV; i++) begin
      exc_vec = T_VEC[i]; ecall = T_ECL[i]; faddr = 64'h8000_0400 + 64'(i);
      step();
      clr();
      chk($sformatf("R2 R3 cause row %0d", i), mcause, 64'(T_COD[i]));
      chk($sformatf("R4 tval row %0d", i), mtval, T_ADR[i] ? 64'h8000_0400 + 64'(i) : 64'h0);
      chk($sformatf("R5 redirect row %0d", i), {redirect, s_trap, priv}, 4'b1011);
      chk($sformatf("R5 status row %0d", i), mstatus, 64'h1800);
      chk($sformatf("R11 target row %0d", i), target, VB);
    end

    wr(3'd1, '1);  chk("R6 edeleg mask", medeleg, 64'hB309);
    wr(3'd2, '1);  chk("R6 ideleg mask", mideleg, 64'h222);
    wr(3'd3, '1);  chk("R6 ien mask", mie, 64'hAAA);

    exc_vec = 7'h04; faddr = 64'h55; step(); clr();
    chk("R7 machine not delegated", {redirect, s_trap}, 2'b10);
    chk("R7 cause", mcause, 3);

    wr(3'd0, 64'h80);  chk("R12 status write", mstatus, 64'h80);
    ret();
    chk("R12 return priv", priv, 2'b00);
    chk("R12 return status", mstatus, 64'h88);

    ecall = 1; step(); clr();
    chk("R7 delegated pulse", {redirect, s_trap}, 2'b01);
    chk("R3 R7 delegated cause", s_cause, 8);
    chk("R7 priv to S", priv, 2'b01);
    chk("R7 mcause kept", mcause, 3);
    chk("R7 status kept", mstatus, 64'h88);

    wr(3'd1, 0);
    ecall = 1; step(); clr();
    chk("R3 ecall from S", mcause, 9);
    chk("R5 stack from S", mstatus, 64'h880);
    chk("R5 priv M", priv, 2'b11);

    ret();
    chk("R12 back to S", {priv, mstatus[15:0]}, {2'b01, 16'h0088});
    ret();
    chk("R12 return in S ignored", {priv, mstatus[15:0]}, {2'b01, 16'h0088});
    chk("R12 no pulse", {redirect, s_trap}, 0);

    tmr = 1; #1;
    chk("R8 pending timer", mip, 64'h0A0);
    step(); clr();
    chk("R9 timer cause", mcause, IRQ | 7);
    chk("R11 vectored timer", target, VB + 28);
    chk("R5 status", mstatus, 64'h880);

    sw = 1; #1;
    chk("R8 pending sw", mip, 64'h008);
    step(); clr();
    chk("R9 gated by MIE", {redirect, s_trap}, 0);
    chk("R9 cause kept", mcause, IRQ | 7);

    wr(3'd0, 64'h8);
    ext = 1; tmr = 1; sw = 1; #1;
    chk("R8 pending all", mip, 64'hAA8);
    step(); clr();
    chk("R9 external wins", mcause, IRQ | 11);
    chk("R11 vectored ext", target, VB + 44);
    chk("R5 status M", mstatus, 64'h1880);

    wr(3'd0, 64'h8);
    sw = 1; tmr = 1; step(); clr();
    chk("R9 software over timer", mcause, IRQ | 3);
    chk("R11 vectored sw", target, VB + 12);

    wr(3'd0, 64'h8);
    tmr = 1; exc_vec = 7'h02; faddr = 64'h1234; step(); clr();
    chk("R9 irq over exception", mcause, IRQ | 7);
    chk("R4 irq tval zero", mtval, 0);

    wr(3'd0, 64'h0);
    ret();
    chk("R12 return to U", {priv, mstatus[15:0]}, {2'b00, 16'h0080});
    wr(3'd3, 64'h200);
    ext = 1; #1;
    chk("R8 pending ext", mip, 64'hA00);
    step(); clr();
    chk("R10 supervisor irq", {redirect, s_trap, priv}, 4'b0101);
    chk("R10 s cause", s_cause, IRQ | 9);
    chk("R10 mcause kept", mcause, IRQ | 7);

    ecall = 1; step(); clr();
    chk("R5 stack S ie0", mstatus, 64'h800);
    wr(3'd0, 64'h8);
    ext = 1; step(); clr();
    chk("R10 ignored in M", {redirect, s_trap, priv}, 4'b0011);
    chk("R10 mcause kept in M", mcause, 9);

    wr(3'd4, 64'h4000);
    wr(3'd3, 64'hFFF);
    tmr = 1; step(); clr();
    chk("R11 direct target", target, 64'h4000);
    chk("R11 direct cause", mcause, IRQ | 7);

    we = 1; sel = 3'd4; wdata = 64'h9000; exc_vec = 7'h04; step(); clr();
    chk("R13 write dropped", mtvec, 64'h4000);
    chk("R13 trap taken", mcause, 3);
    chk("R13 status", mstatus, 64'h1800);
    wr(3'd0, 64'h1000);
    chk("R13 pp 10 ignored", mstatus, 64'h1800);

    done = 1;
    summary();
    $finish;
  end
endmodule